// File: doc/BRIEF.md
# Reference Clock Source Selector

This block decides which of three candidate clocks feeds a downstream phase-locked loop, or tells that loop to freeze its current state (digital hold) and keep running without fresh phase or frequency information. The three candidates are input A, input B and the reference input F. The block does not contain the PLL or the alarm detectors. It only consumes their per-input flags and drives the selection.

In manual mode a 2-bit control code picks the source. A raw code is never used directly. It first passes through a stability filter, so that a bouncing or momentarily wrong code cannot switch the clock. In automatic mode the manual code is ignored. The block then picks the highest-priority input that has no loss-of-signal flag and no active frequency-offset alarm. Offset alarms exist only for A and B, and they can be switched off as a group, in which case loss-of-signal alone decides. When no input qualifies, the block commands digital hold. Every change of selection is registered and appears on one clock edge, on three separately held outputs: an encoded code, a one-hot vector and a hold flag.

Top module: `clk_src_select`

## Requirements
- R1: While reset is asserted, and after its release until a selection is made, the outputs show digital hold: `selCode` = 11, `selOneHot` = 000 and `holdActive` = 1.
- R2: In manual mode an accepted code maps as follows. 00 selects F: `selCode` 00, `selOneHot` 001. 01 selects B: `selCode` 01, `selOneHot` 010. 10 selects A: `selCode` 10, `selOneHot` 100. 11 commands hold: `selCode` 11, `selOneHot` 000, `holdActive` 1.
- R3: A new manual code is accepted only after it has been sampled unchanged on STABLE_CYCLES (default 16) consecutive rising edges. In manual mode the outputs show it after the next edge, which is the 17th edge counted from the first sample. A code that lasts fewer edges changes nothing.
- R4: While `autoMode` is 1, `manCode` has no effect on the outputs. When `autoMode` falls, the last code that the filter accepted takes effect on the next edge.
- R5: In automatic mode, A counts as usable when `lossA` = 0 and either `offA` = 0 or `offDisable` = 1. B follows the same rule with `lossB` and `offB`. F is usable when `lossF` = 0.
- R6: In automatic mode the block selects A if A is usable. Otherwise it selects B if B is usable. Otherwise it selects F if F is usable.
- R7: In automatic mode, when no input is usable, the block commands hold. It leaves hold for the highest-priority usable input as soon as one exists.
- R8: With `offDisable` = 1, the offset alarms `offA` and `offB` have no effect on the automatic choice.
- R9: In automatic mode the outputs after a rising edge reflect the inputs sampled at that edge, with exactly one edge of latency.
- R10: At every cycle `selOneHot` has at most one bit set. `holdActive` is 1 exactly when `selOneHot` is zero. `selCode` is 11 exactly when `holdActive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoMode | input | 1 | 1 = automatic selection, 0 = manual code |
| manCode | input | 2 | Raw manual selection code |
| lossA | input | 1 | Loss-of-signal flag for input A |
| lossB | input | 1 | Loss-of-signal flag for input B |
| lossF | input | 1 | Loss-of-signal flag for reference input F |
| offA | input | 1 | Frequency-offset alarm for input A |
| offB | input | 1 | Frequency-offset alarm for input B |
| offDisable | input | 1 | 1 = ignore frequency-offset alarms |
| selCode | output | 2 | Encoded selection (00 F, 01 B, 10 A, 11 hold) |
| selOneHot | output | 3 | One-hot selection {A, B, F} |
| holdActive | output | 1 | Digital hold commanded |

## Verification
The assertions check on every cycle that the three output registers agree with each other and that the strobes are exclusive. They also check that, one edge after automatic-mode inputs are sampled, the outputs show the choice those inputs call for, including hold when nothing is usable. The stability filter cannot be expressed as a short property, so only the bench scenarios show it. They cover the exact 16/17-edge acceptance window, pulses that are one edge too short, the handover from automatic back to manual mode, and the fact that the manual code is ignored in automatic mode.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  localparam int CODE_W = 2;
  localparam int NUM_SRC = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_F    = 2'b00,
    SRC_B    = 2'b01,
    SRC_A    = 2'b10,
    SRC_HOLD = 2'b11
  } srcSel_e;

  // Strobes from control to datapath; at most one set per cycle.
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadF;
    logic loadHold;
  } selStrobe_t;

endpackage

// File: rtl/code_deglitch.sv
module code_deglitch #(
  parameter int WIDTH = 2,
  parameter int STABLE_CYCLES = 16,
  parameter logic [WIDTH-1:0] RESET_CODE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawCode,
  output logic [WIDTH-1:0] cleanCode
);

  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(STABLE_CYCLES - 1);

  logic [WIDTH-1:0] candCode;
  logic [CNT_W-1:0] matchCnt;

  // matchCnt counts edges on which rawCode equalled candCode, including
  // the edge that loaded it; the edge that finds it saturated accepts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candCode  <= RESET_CODE;
      matchCnt  <= CNT_DONE;
      cleanCode <= RESET_CODE;
    end else if (rawCode != candCode) begin
      candCode <= rawCode;
      matchCnt <= CNT_W'(1);
    end else if (matchCnt == CNT_DONE) begin
      cleanCode <= candCode;
    end else begin
      matchCnt <= matchCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/src_sel_ctrl.sv
module src_sel_ctrl
  import clk_src_pkg::*;
(
  input  logic              autoMode,
  input  logic [CODE_W-1:0] manCodeClean,
  input  logic              lossA,
  input  logic              lossB,
  input  logic              lossF,
  input  logic              offA,
  input  logic              offB,
  input  logic              offDisable,
  input  srcSel_e           curSel,
  output selStrobe_t        strobe
);

  logic validA, validB, validF;
  srcSel_e autoTarget, target;

  always_comb begin
    validA = !lossA && (offDisable || !offA);
    validB = !lossB && (offDisable || !offB);
    validF = !lossF;

    if (validA)      autoTarget = SRC_A;
    else if (validB) autoTarget = SRC_B;
    else if (validF) autoTarget = SRC_F;
    else             autoTarget = SRC_HOLD;

    target = autoMode ? autoTarget : srcSel_e'(manCodeClean);

    strobe = '0;
    if (target != curSel) begin
      case (target)
        SRC_A:   strobe.loadA    = 1'b1;
        SRC_B:   strobe.loadB    = 1'b1;
        SRC_F:   strobe.loadF    = 1'b1;
        default: strobe.loadHold = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/src_sel_dp.sv
module src_sel_dp
  import clk_src_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  selStrobe_t         strobe,
  output srcSel_e            selCode,
  output logic [NUM_SRC-1:0] selOneHot,
  output logic               holdActive
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCode    <= SRC_HOLD;
      selOneHot  <= '0;
      holdActive <= 1'b1;
    end else if (strobe.loadA) begin
      selCode    <= SRC_A;
      selOneHot  <= 3'b100;
      holdActive <= 1'b0;
    end else if (strobe.loadB) begin
      selCode    <= SRC_B;
      selOneHot  <= 3'b010;
      holdActive <= 1'b0;
    end else if (strobe.loadF) begin
      selCode    <= SRC_F;
      selOneHot  <= 3'b001;
      holdActive <= 1'b0;
    end else if (strobe.loadHold) begin
      selCode    <= SRC_HOLD;
      selOneHot  <= '0;
      holdActive <= 1'b1;
    end
  end

endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import clk_src_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoMode,
  input  logic [1:0]  manCode,
  input  logic        lossA,
  input  logic        lossB,
  input  logic        lossF,
  input  logic        offA,
  input  logic        offB,
  input  logic        offDisable,
  output logic [1:0]  selCode,
  output logic [2:0]  selOneHot,
  output logic        holdActive
);

  logic [CODE_W-1:0] manCodeClean;
  selStrobe_t selStrobe;
  srcSel_e curSel;

  code_deglitch #(
    .WIDTH(CODE_W),
    .STABLE_CYCLES(STABLE_CYCLES),
    .RESET_CODE(SRC_HOLD)
  ) i_deglitch (
    .clk(clk),
    .rstN(rstN),
    .rawCode(manCode),
    .cleanCode(manCodeClean)
  );

  src_sel_ctrl i_ctrl (
    .autoMode(autoMode),
    .manCodeClean(manCodeClean),
    .lossA(lossA),
    .lossB(lossB),
    .lossF(lossF),
    .offA(offA),
    .offB(offB),
    .offDisable(offDisable),
    .curSel(curSel),
    .strobe(selStrobe)
  );

  src_sel_dp i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(selStrobe),
    .selCode(curSel),
    .selOneHot(selOneHot),
    .holdActive(holdActive)
  );

  assign selCode = curSel;

endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk (
  input logic       clk,
  input logic       rstN,
  input logic       autoMode,
  input logic       lossA,
  input logic       lossB,
  input logic       lossF,
  input logic       offA,
  input logic       offB,
  input logic       offDisable,
  input logic [1:0] selCode,
  input logic [2:0] selOneHot,
  input logic       holdActive,
  input logic [3:0] strobeBits
);

  logic okA, okB, okF;
  assign okA = !lossA && (offDisable || !offA);
  assign okB = !lossB && (offDisable || !offB);
  assign okF = !lossF;

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOneHot)); // R10

  AST_HOLD_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    holdActive == (selOneHot == 3'b000)); // R10

  AST_HOLD_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rstN)
    holdActive == (selCode == 2'b11)); // R10

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeBits)); // R10

  AST_AUTO_PICKS_A: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && okA) |=> (selOneHot == 3'b100 && selCode == 2'b10)); // R6

  AST_AUTO_PICKS_B: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !okA && okB) |=> (selOneHot == 3'b010 && selCode == 2'b01)); // R5

  AST_AUTO_PICKS_F: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !okA && !okB && okF) |=> (selOneHot == 3'b001)); // R9

  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !okA && !okB && !okF) |=> holdActive); // R7

endmodule

bind clk_src_select clk_src_select_chk i_chk (
  .clk(clk),
  .rstN(rstN),
  .autoMode(autoMode),
  .lossA(lossA),
  .lossB(lossB),
  .lossF(lossF),
  .offA(offA),
  .offB(offB),
  .offDisable(offDisable),
  .selCode(selCode),
  .selOneHot(selOneHot),
  .holdActive(holdActive),
  .strobeBits(selStrobe)
);

// File: tb/test_clk_src_select.sv
module test_clk_src_select;

  localparam int CLK_PERIOD = 10;
  localparam int STABLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoMode = 1'b0;
  logic [1:0] manCode = 2'b00;
  logic lossA = 1'b0, lossB = 1'b0, lossF = 1'b0;
  logic offA = 1'b0, offB = 1'b0, offDisable = 1'b0;
  logic [1:0] selCode;
  logic [2:0] selOneHot;
  logic holdActive;

  int nChecks = 0;
  int nFails = 0;
  bit summaryDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_select #(.STABLE_CYCLES(STABLE)) i_clk_src_select (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .manCode(manCode),
    .lossA(lossA), .lossB(lossB), .lossF(lossF),
    .offA(offA), .offB(offB), .offDisable(offDisable),
    .selCode(selCode), .selOneHot(selOneHot), .holdActive(holdActive)
  );

  function automatic logic [2:0] vecOf(input logic [1:0] c);
    case (c)
      2'b00:   return 3'b001;
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] autoExpect(input logic la, lb, lf, oa, ob, od);
    if (!la && (od || !oa)) return 2'b10;
    if (!lb && (od || !ob)) return 2'b01;
    if (!lf) return 2'b00;
    return 2'b11;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectSel(input logic [1:0] exp, input string req);
    logic [2:0] expVec;
    logic expHold;
    expVec = vecOf(exp);
    expHold = (exp == 2'b11);
    nChecks++;
    if (selCode !== exp || selOneHot !== expVec || holdActive !== expHold) begin
      nFails++;
      $display("FAIL %s: code=%b vec=%b hold=%b expected code=%b vec=%b hold=%b",
               req, selCode, selOneHot, holdActive, exp, expVec, expHold);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [1:0] prev;
    // R1: reset state
    tick(3);
    expectSel(2'b11, "R1 during reset");
    rstN = 1'b1;
    tick(1);
    expectSel(2'b11, "R1 after release");

    // R3: first code 00 shows up after exactly 17 edges from release
    tick(STABLE - 1);
    expectSel(2'b11, "R3 before window");
    tick(1);
    expectSel(2'b00, "R2 R3 code 00 -> F");

    // R2 R3: walk every code with exact window edges
    prev = 2'b00;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] c;
      c = (k == 0) ? 2'b01 : (k == 1) ? 2'b10 : (k == 2) ? 2'b11 : 2'b00;
      manCode = c;
      tick(STABLE);
      expectSel(prev, "R3 window not yet met");
      tick(1);
      expectSel(c, "R2 mapping after window");
      prev = c;
    end

    // R3: short pulses of every length below the window change nothing
    for (int len = 1; len < STABLE; len++) begin
      manCode = 2'b10;
      tick(len);
      expectSel(2'b00, "R3 during short pulse");
      manCode = 2'b00;
      tick(STABLE + 4);
      expectSel(2'b00, "R3 after short pulse");
    end

    // R3: a pulse of exactly the window length is accepted
    manCode = 2'b01;
    tick(STABLE);
    manCode = 2'b00;
    tick(1);
    expectSel(2'b01, "R3 pulse of full window accepted");
    tick(STABLE + 1);
    expectSel(2'b00, "R3 return after full window");

    // R5 R6 R7 R8 R9 R4: exhaustive sweep of alarm inputs in automatic mode
    autoMode = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      b = 6'(v);
      {offDisable, offB, offA, lossF, lossB, lossA} = b;
      manCode = 2'(v);  // R4: toggling every cycle, must be ignored
      tick(1);
      expectSel(autoExpect(lossA, lossB, lossF, offA, offB, offDisable),
                b[5] ? "R8 R9 auto sweep offsets off" : "R5 R6 R9 auto sweep");
    end

    // R7: enter hold then leave for best usable input
    {lossA, lossB, lossF, offA, offB, offDisable} = 6'b111000;
    tick(1);
    expectSel(2'b11, "R7 all lost -> hold");
    lossF = 1'b0;
    tick(1);
    expectSel(2'b00, "R7 leave hold to F");
    lossB = 1'b0;
    tick(1);
    expectSel(2'b01, "R6 B over F");
    lossA = 1'b0; offA = 1'b1;
    tick(1);
    expectSel(2'b01, "R5 A blocked by offset");
    offDisable = 1'b1;
    tick(1);
    expectSel(2'b10, "R8 offset ignored, A chosen");

    // R4: stable manual code held in auto mode has no effect, then hands over
    manCode = 2'b01;
    tick(STABLE + 4);
    expectSel(2'b10, "R4 manual ignored in auto");
    autoMode = 1'b0;
    tick(1);
    expectSel(2'b01, "R4 handover to accepted manual code");
    lossB = 1'b1;
    tick(1);
    expectSel(2'b01, "R4 manual ignores alarms");

    // R1: reset mid-run returns to hold
    rstN = 1'b0;
    tick(1);
    expectSel(2'b11, "R1 reset mid-run");
    rstN = 1'b1;
    tick(2);
    expectSel(2'b11, "R1 hold until window after reset");

    finishRun();
  end

endmodule